// File: doc/BRIEF.md
# Tournament Direction Predictor

This block predicts whether a conditional branch will be taken. It runs two predictors side by side and uses a third table to decide which one to trust for each branch.

- The local predictor uses the branch address to pick one of several per-branch history registers. That history then indexes a table of 2-bit counters.
- The global predictor indexes its own table of 2-bit counters with a shift register holding the outcomes of the most recent retired branches.
- A chooser table, indexed by the same global history, holds 2-bit counters that select between the two component predictions.

The predict side is purely combinational. The fetch logic presents a branch address and gets back four things in the same cycle: the final direction, both component predictions, and the two table indices used. It keeps these with the branch until the branch resolves.

At retirement the pipeline returns the address, the actual outcome, and the saved predictions and indices. On that clock edge every structure is trained. Target prediction and flush control live elsewhere.

Top module: `tourn_pred`

## Requirements
- R1: After reset every history register reads zero, every direction counter is 01 (weakly not-taken) and every chooser counter is 10 (weakly prefer global). So the first prediction for any address is not-taken, with both indices zero.
- R2: The local history register is selected by address bits [2 +: log2(N_LHR)] (bits [5:2] with 16 registers). Its value is presented as `pred_lidx_o`. A valid retire shifts that register left and inserts the actual outcome at bit 0.
- R3: `pred_local_o` is bit 1 of the local table counter addressed by `pred_lidx_o`. A valid retire moves the counter at `ret_lidx_i` one step toward the actual outcome (up when taken).
- R4: `pred_gidx_o` equals the global history. A valid retire shifts the global history left and inserts the actual outcome at bit 0.
- R5: `pred_global_o` is bit 1 of the global table counter addressed by `pred_gidx_o`. A valid retire moves the counter at `ret_gidx_i` one step toward the actual outcome.
- R6: `pred_taken_o` equals `pred_global_o` when bit 1 of the chooser counter at the global history is 1, and `pred_local_o` otherwise.
- R7: On a valid retire with `ret_local_i` different from `ret_global_i`, the chooser counter at `ret_gidx_i` steps up if the global prediction matched the outcome, and down otherwise. When the two agree, the chooser counter is left unchanged.
- R8: All counters saturate: an up-step at 11 stays 11 and a down-step at 00 stays 00.
- R9: With `ret_valid_i` low, no history register or counter changes, whatever the other retire inputs carry.
- R10: Both direction tables and both histories are trained on every valid retire, regardless of which component the chooser selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pred_pc_i | input | PC_W | Address of the branch being predicted |
| pred_taken_o | output | 1 | Final predicted direction |
| pred_local_o | output | 1 | Local component prediction |
| pred_global_o | output | 1 | Global component prediction |
| pred_lidx_o | output | LHIST_W | Local table index (selected local history) |
| pred_gidx_o | output | GHIST_W | Global table and chooser index (global history) |
| ret_valid_i | input | 1 | A branch retires this cycle |
| ret_pc_i | input | PC_W | Address of the retiring branch |
| ret_taken_i | input | 1 | Actual outcome of the retiring branch |
| ret_local_i | input | 1 | Saved local prediction |
| ret_global_i | input | 1 | Saved global prediction |
| ret_lidx_i | input | LHIST_W | Saved local table index |
| ret_gidx_i | input | GHIST_W | Saved global table index |

## Verification
A reduced configuration is used: four local registers, and 4-bit local and global histories. The bench tracks every counter and history of this configuration in its own model. It drives four outcome patterns over eight addresses, several of which alias onto the same local register:
- All-taken drives counters into upper saturation.
- Per-address alternation favours the local component over the global one.
- A period-three loop on one address, mixed with random branches, makes the components disagree and moves the chooser both ways.
- A pseudo-random phase with idle cycles carrying junk retire data shows that state is not touched without a valid retire.

// File: rtl/tourn_pkg.sv
package tourn_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_NT  = 2'b01;
  localparam ctr2_t CTR_WEAK_GLB = 2'b10;

  // saturating step toward up/down
  function automatic ctr2_t ctr_step(ctr2_t c, logic up);
    ctr2_t r;
    r = c;
    if (up && c != 2'b11) r = c + 2'b01;
    else if (!up && c != 2'b00) r = c - 2'b01;
    return r;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tourn_pkg::*;
#(
  parameter int    ENTRIES = 1024,
  parameter ctr2_t INIT    = CTR_WEAK_NT,
  localparam int   IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_msb_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_up_i
);
  ctr2_t mem_q [ENTRIES];

  assign rd_msb_o = mem_q[rd_idx_i][1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= INIT;
    end else if (upd_en_i) begin
      mem_q[upd_idx_i] <= ctr_step(mem_q[upd_idx_i], upd_up_i);
    end
  end

  a_r8_sat_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_up_i && mem_q[upd_idx_i] == 2'b11)
    |=> mem_q[$past(upd_idx_i)] == 2'b11);

  a_r8_sat_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !upd_up_i && mem_q[upd_idx_i] == 2'b00)
    |=> mem_q[$past(upd_idx_i)] == 2'b00);

  // R3/R5: single step per update
  a_r3_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_up_i && mem_q[upd_idx_i] != 2'b11)
    |=> mem_q[$past(upd_idx_i)] == $past(mem_q[upd_idx_i]) + 2'b01);

  a_r9_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_en_i) |=> mem_q[$past(rd_idx_i)] == $past(mem_q[rd_idx_i]));
endmodule

// File: rtl/tp_local_hist.sv
module tp_local_hist #(
  parameter int  PC_W   = 32,
  parameter int  N_LHR  = 16,
  parameter int  HIST_W = 10,
  localparam int SEL_W  = $clog2(N_LHR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   rd_pc_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              upd_en_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic              upd_taken_i
);
  logic [HIST_W-1:0] hist_q [N_LHR];
  logic [SEL_W-1:0]  rd_sel, upd_sel;
  logic              unused_pc_bits;

  // word-aligned addresses: skip bits [1:0]
  assign rd_sel  = rd_pc_i[2 +: SEL_W];
  assign upd_sel = upd_pc_i[2 +: SEL_W];
  assign unused_pc_bits = ^{rd_pc_i, upd_pc_i};
  assign rd_hist_o = hist_q[rd_sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LHR; i++) hist_q[i] <= '0;
    end else if (upd_en_i) begin
      hist_q[upd_sel] <= {hist_q[upd_sel][HIST_W-2:0], upd_taken_i};
    end
  end

  a_r2_newest_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> hist_q[$past(upd_sel)][0] == $past(upd_taken_i));

  a_r9_lhr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_en_i) |=> hist_q[$past(rd_sel)] == $past(hist_q[rd_sel]));
endmodule

// File: rtl/tp_global_hist.sv
module tp_global_hist #(
  parameter int HIST_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic              upd_taken_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (upd_en_i) hist_q <= {hist_q[HIST_W-2:0], upd_taken_i};
  end

  assign hist_o = hist_q;

  a_r4_ghr_age: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));

  a_r9_ghr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_en_i) |=> $stable(hist_q));
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred
  import tourn_pkg::*;
#(
  parameter int  PC_W    = 32,
  parameter int  N_LHR   = 16,
  parameter int  LHIST_W = 10,
  parameter int  GHIST_W = 12,
  localparam int LPT_N   = 1 << LHIST_W,
  localparam int GPT_N   = 1 << GHIST_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PC_W-1:0]    pred_pc_i,
  output logic               pred_taken_o,
  output logic               pred_local_o,
  output logic               pred_global_o,
  output logic [LHIST_W-1:0] pred_lidx_o,
  output logic [GHIST_W-1:0] pred_gidx_o,
  input  logic               ret_valid_i,
  input  logic [PC_W-1:0]    ret_pc_i,
  input  logic               ret_taken_i,
  input  logic               ret_local_i,
  input  logic               ret_global_i,
  input  logic [LHIST_W-1:0] ret_lidx_i,
  input  logic [GHIST_W-1:0] ret_gidx_i
);
  logic [LHIST_W-1:0] lhist;
  logic [GHIST_W-1:0] ghist;
  logic               use_global;
  logic               disagree;

  tp_local_hist #(.PC_W(PC_W), .N_LHR(N_LHR), .HIST_W(LHIST_W)) i_lhist (
    .clk_i, .rst_ni,
    .rd_pc_i(pred_pc_i), .rd_hist_o(lhist),
    .upd_en_i(ret_valid_i), .upd_pc_i(ret_pc_i), .upd_taken_i(ret_taken_i)
  );

  tp_global_hist #(.HIST_W(GHIST_W)) i_ghist (
    .clk_i, .rst_ni,
    .upd_en_i(ret_valid_i), .upd_taken_i(ret_taken_i), .hist_o(ghist)
  );

  tp_ctr_table #(.ENTRIES(LPT_N), .INIT(CTR_WEAK_NT)) i_lpt (
    .clk_i, .rst_ni,
    .rd_idx_i(lhist), .rd_msb_o(pred_local_o),
    .upd_en_i(ret_valid_i), .upd_idx_i(ret_lidx_i), .upd_up_i(ret_taken_i)
  );

  tp_ctr_table #(.ENTRIES(GPT_N), .INIT(CTR_WEAK_NT)) i_gpt (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist), .rd_msb_o(pred_global_o),
    .upd_en_i(ret_valid_i), .upd_idx_i(ret_gidx_i), .upd_up_i(ret_taken_i)
  );

  // chooser trains only on disagreement, toward the correct side
  assign disagree = ret_local_i ^ ret_global_i;

  tp_ctr_table #(.ENTRIES(GPT_N), .INIT(CTR_WEAK_GLB)) i_cho (
    .clk_i, .rst_ni,
    .rd_idx_i(ghist), .rd_msb_o(use_global),
    .upd_en_i(ret_valid_i && disagree), .upd_idx_i(ret_gidx_i),
    .upd_up_i(ret_global_i == ret_taken_i)
  );

  assign pred_lidx_o  = lhist;
  assign pred_gidx_o  = ghist;
  assign pred_taken_o = use_global ? pred_global_o : pred_local_o;

  a_r6_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_local_o == pred_global_o) |-> pred_taken_o == pred_local_o);

  a_r4_gidx_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_valid_i |=> pred_gidx_o[0] == $past(ret_taken_i));
endmodule

// File: tb/test_tourn_pred.sv
module test_tourn_pred;
  localparam int PC_W = 16, N_LHR = 4, LW = 4, GW = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [PC_W-1:0] pred_pc_i = '0, ret_pc_i = '0;
  logic pred_taken_o, pred_local_o, pred_global_o;
  logic [LW-1:0] pred_lidx_o, ret_lidx_i = '0;
  logic [GW-1:0] pred_gidx_o, ret_gidx_i = '0;
  logic ret_valid_i = 1'b0, ret_taken_i = 1'b0, ret_local_i = 1'b0, ret_global_i = 1'b0;

  tourn_pred #(.PC_W(PC_W), .N_LHR(N_LHR), .LHIST_W(LW), .GHIST_W(GW)) i_tourn_pred (
    .clk_i, .rst_ni, .pred_pc_i, .pred_taken_o, .pred_local_o, .pred_global_o,
    .pred_lidx_o, .pred_gidx_o, .ret_valid_i, .ret_pc_i, .ret_taken_i,
    .ret_local_i, .ret_global_i, .ret_lidx_i, .ret_gidx_i
  );

  always #4 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int n_local_win = 0, n_cho_move = 0, n_sat = 0;

  logic [LW-1:0] m_lhr [N_LHR];
  logic [1:0]    m_lpt [1 << LW];
  logic [1:0]    m_gpt [1 << GW];
  logic [1:0]    m_cho [1 << GW];
  logic [GW-1:0] m_ghr;
  logic [15:0]   lfsr = 16'hACE1;

  function automatic logic [1:0] sat(logic [1:0] c, logic up);
    if (up) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic step(logic [PC_W-1:0] pc, logic tk, logic vld);
    logic [1:0] sel;
    logic [LW-1:0] li;
    logic [GW-1:0] gi;
    logic el, eg, ef;
    @(negedge clk_i);
    pred_pc_i = pc;
    #1;
    sel = pc[3:2];
    li = m_lhr[sel];
    gi = m_ghr;
    el = m_lpt[li][1];
    eg = m_gpt[gi][1];
    ef = m_cho[gi][1] ? eg : el;
    chk(pred_lidx_o == li, "R2 lidx", pred_lidx_o, li);
    chk(pred_local_o == el, "R3 local", pred_local_o, el);
    chk(pred_gidx_o == gi, "R4 gidx", pred_gidx_o, gi);
    chk(pred_global_o == eg, "R5 global", pred_global_o, eg);
    chk(pred_taken_o == ef, "R6/R7 final", pred_taken_o, ef);
    if (!m_cho[gi][1] && el != eg) n_local_win++;
    ret_valid_i = vld;
    if (vld) begin
      ret_pc_i = pc; ret_taken_i = tk; ret_local_i = el; ret_global_i = eg;
      ret_lidx_i = li; ret_gidx_i = gi;
    end else begin
      next_rand();
      ret_pc_i = lfsr; ret_taken_i = lfsr[3]; ret_local_i = lfsr[5];
      ret_global_i = ~lfsr[5]; ret_lidx_i = lfsr[9:6]; ret_gidx_i = lfsr[13:10];
    end
    @(posedge clk_i);
    if (vld) begin
      // R10: all structures trained every valid retire
      if ((m_lpt[li] == 2'b11 && tk) || (m_lpt[li] == 2'b00 && !tk)) n_sat++;
      m_lpt[li] = sat(m_lpt[li], tk);
      m_gpt[gi] = sat(m_gpt[gi], tk);
      if (el != eg) begin
        m_cho[gi] = sat(m_cho[gi], eg == tk);
        n_cho_move++;
      end
      m_lhr[sel] = {m_lhr[sel][LW-2:0], tk};
      m_ghr = {m_ghr[GW-2:0], tk};
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N_LHR; i++) m_lhr[i] = '0;
    for (int i = 0; i < (1 << LW); i++) m_lpt[i] = 2'b01;
    for (int i = 0; i < (1 << GW); i++) begin m_gpt[i] = 2'b01; m_cho[i] = 2'b10; end
    m_ghr = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    pred_pc_i = 16'h1234;
    #1;
    chk(pred_taken_o == 1'b0, "R1 final", pred_taken_o, 0);
    chk(pred_local_o == 1'b0, "R1 local", pred_local_o, 0);
    chk(pred_global_o == 1'b0, "R1 global", pred_global_o, 0);
    chk(pred_lidx_o == '0, "R1 lidx", pred_lidx_o, 0);
    chk(pred_gidx_o == '0, "R1 gidx", pred_gidx_o, 0);

    // all taken, eight addresses aliasing onto four registers
    for (int n = 0; n < 200; n++) step(16'h1000 + 16'(4 * (n % 8)), 1'b1, 1'b1);
    // per-address alternation
    for (int n = 0; n < 240; n++) step(16'h2000 + 16'(4 * (n % 4)), 1'((n / 4) % 2), 1'b1);
    // period-three loop on one address mixed with random branches
    for (int n = 0; n < 300; n++) begin
      next_rand();
      if (n % 2 == 0) step(16'h3008, 1'((n / 2) % 3 != 2), 1'b1);
      else step(16'h3000 + 16'(4 * lfsr[2:0]), lfsr[7], 1'b1);
    end
    // random with idle cycles carrying junk (R9)
    for (int n = 0; n < 400; n++) begin
      next_rand();
      step(16'h4000 + 16'(4 * lfsr[4:2]), lfsr[8] | lfsr[1], lfsr[11:10] != 2'b00);
    end
    ret_valid_i = 1'b0;
    chk(n_local_win > 0, "R7 chooser selected local", n_local_win, 1);
    chk(n_cho_move > 0, "R7 chooser trained", n_cho_move, 1);
    chk(n_sat > 0, "R8 saturation reached", n_sat, 1);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule